// File: doc/BRIEF.md
# Stream Stall Timeout Timer

This block watches the output side of a streaming transfer and flags a stall that lasts too long. While the timer is enabled, the transfer still has bytes to send, and the downstream sink holds its ready low, a prescaler divides the clock and a tick counter counts the divided ticks. When the tick count reaches the programmed limit, the block emits a one-cycle timeout event. Interrupt status capture and masking happen outside the block.

Any accepted beat, a drained transfer, or a cleared enable stops the timer and clears both counters, so every new stall is timed from zero. The timer is one-shot: after it fires, it stays quiet until the stall condition goes away for at least one cycle. A typical setting divides by 4096 and counts 4094 ticks. The bench uses small settings.

Top module: `stream_stall_timer`

## Requirements
- R1: The timer counts only in a cycle where `tmo_en`=1, `bytes_pending`=1 and `sink_ready`=0 (a stalled cycle); no other input combination ever produces a timeout event.
- R2: With prescaler `presc_val`=P and limit `limit_val`=L (L nonzero), the event appears in the cycle after the L*(P+1)-th consecutive stalled cycle.
- R3: `timeout_o` is high for exactly one cycle per expiry.
- R4: After an expiry, no further event is produced while the stall continues; one non-stalled cycle re-arms the timer, and the next stall is timed from zero.
- R5: A cycle with `bytes_pending`=1 and `sink_ready`=1 (an accepted beat) clears both counters, so the following stall needs the full L*(P+1) cycles again.
- R6: Clearing `tmo_en` for one cycle clears the counters and suppresses the event, including when the clear falls in the cycle that would have expired.
- R7: A limit of 0 acts as a limit of 1, so the event follows the (P+1)-th stalled cycle.
- R8: During and right after reset, `timeout_o` is 0 and both counters are zero.
- R9: A cycle with `bytes_pending`=0 stops the timer and clears the counters, just like an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_en | input | 1 | Timeout enable |
| presc_val | input | PRE_W (12) | Prescaler; the tick period is presc_val+1 cycles |
| limit_val | input | LIM_W (12) | Number of ticks to expiry (0 treated as 1) |
| bytes_pending | input | 1 | Transfer still has data left to send |
| sink_ready | input | 1 | Downstream sink accepts data this cycle |
| timeout_o | output | 1 | One-cycle stall timeout event |

## Verification
The properties assume that `presc_val` and `limit_val` stay constant through a stall. A change that happens only while the timer is stopped is always safe, because the counters restart from zero. The stimulus follows this rule: it picks new settings only in cycles where it drives a non-stalled input pattern, and it randomises the stall and break lengths between them. The bench reference model counts consecutive stalled cycles against L*(P+1), so it relies on the same assumption.

// File: rtl/stt_pkg.sv
package stt_pkg;

  // Stall condition: enabled, data left, sink refusing.
  function automatic logic stall_cond(input logic en, input logic pend, input logic rdy);
    return en & pend & ~rdy;
  endfunction

  // Prescaler wraps once its count has reached the programmed value.
  function automatic logic wrap_now(input int unsigned cnt, input int unsigned top);
    return cnt >= top;
  endfunction

  // A zero limit behaves as one tick.
  function automatic int unsigned eff_limit(input int unsigned lim);
    return (lim == 0) ? 1 : lim;
  endfunction

  // The tick in progress completes the limit.
  function automatic logic limit_hit(input int unsigned ticks_done, input int unsigned lim);
    return (ticks_done + 1) >= eff_limit(lim);
  endfunction

endpackage

// File: rtl/stt_stall_gate.sv
module stt_stall_gate
  import stt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pend,
  input  logic rdy,
  input  logic expire,
  output logic stall,
  output logic run_en,
  output logic spent
);

  assign stall  = stall_cond(en, pend, rdy);
  assign run_en = stall & ~spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      spent <= 1'b0;
    else if (!stall) spent <= 1'b0;
    else if (expire) spent <= 1'b1;
  end

endmodule

// File: rtl/stt_prescaler.sv
module stt_prescaler
  import stt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PRE_W-1:0] presc,
  output logic [PRE_W-1:0] pc,
  output logic             tick
);

  logic wrap;
  assign wrap = wrap_now(32'(pc), 32'(presc));
  assign tick = run_en & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (!run_en) pc <= '0;
    else if (wrap)    pc <= '0;
    else              pc <= pc + 1'b1;
  end

endmodule

// File: rtl/stt_tick_count.sv
module stt_tick_count
  import stt_pkg::*;
#(
  parameter int LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic [LIM_W-1:0] tc,
  output logic             expire
);

  assign expire = tick & limit_hit(32'(tc), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc <= '0;
    else if (!run_en) tc <= '0;
    else if (expire)  tc <= '0;
    else if (tick)    tc <= tc + 1'b1;
  end

endmodule

// File: rtl/stream_stall_timer.sv
module stream_stall_timer #(
  parameter int PRE_W = 12,
  parameter int LIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en,
  input  logic [PRE_W-1:0] presc_val,
  input  logic [LIM_W-1:0] limit_val,
  input  logic             bytes_pending,
  input  logic             sink_ready,
  output logic             timeout_o
);

  logic stall, run_en, spent, tick, expire;
  logic [PRE_W-1:0] pc;
  logic [LIM_W-1:0] tc;

  stt_stall_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(tmo_en), .pend(bytes_pending), .rdy(sink_ready),
    .expire(expire), .stall(stall), .run_en(run_en), .spent(spent)
  );

  stt_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .presc(presc_val), .pc(pc), .tick(tick)
  );

  stt_tick_count #(.LIM_W(LIM_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .limit(limit_val),
    .tc(tc), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_o <= 1'b0;
    else        timeout_o <= expire;
  end

endmodule

// File: rtl/stream_stall_timer_chk.sv
module stream_stall_timer_chk #(
  parameter int PRE_W = 12,
  parameter int LIM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmo_en,
  input logic             bytes_pending,
  input logic             sink_ready,
  input logic             timeout_o,
  input logic             stall,
  input logic             tick,
  input logic             expire,
  input logic             spent,
  input logic [PRE_W-1:0] pc,
  input logic [LIM_W-1:0] tc
);

  // R1
  no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmo_en && bytes_pending && !sink_ready) |-> !tick);

  // R1
  pulse_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $past(tmo_en && bytes_pending && !sink_ready));

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R4
  spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && stall) |-> !expire);

  // R5
  progress_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_pending && sink_ready) |=> !timeout_o);

  // R5
  counters_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc == '0 && tc == '0));

  // R6
  en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |=> !timeout_o);

endmodule

bind stream_stall_timer stream_stall_timer_chk #(.PRE_W(PRE_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .bytes_pending(bytes_pending),
  .sink_ready(sink_ready), .timeout_o(timeout_o), .stall(stall), .tick(tick),
  .expire(expire), .spent(spent), .pc(pc), .tc(tc)
);

// File: tb/stream_stall_timer_tb.sv
module stream_stall_timer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pend = 1'b0, rdy = 1'b0;
  logic [11:0] presc = '0, lim = '0;
  logic timeout_o;

  int total = 0, bad = 0;
  string cur_req = "R8";
  bit finished = 0;

  always #5 clk = ~clk;

  stream_stall_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_en(en), .presc_val(presc), .limit_val(lim),
    .bytes_pending(pend), .sink_ready(rdy), .timeout_o(timeout_o)
  );

  function automatic int target_cycles(input int p, input int l);
    return ((l == 0) ? 1 : l) * (p + 1);
  endfunction

  // Reference: count consecutive stalled cycles against the target.
  int m_n = 0;
  bit m_spent = 0, m_pulse = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_spent = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (!(en && pend && !rdy)) begin
        m_n = 0; m_spent = 0;
      end else if (!m_spent) begin
        if (m_n + 1 == target_cycles(int'(presc), int'(lim))) begin
          m_pulse = 1; m_spent = 1; m_n = 0;
        end else m_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison with the reference model.
  always @(negedge clk) begin
    if (rst_n && !finished)
      check(timeout_o == m_pulse, cur_req, int'(timeout_o), int'(m_pulse));
  end

  // Apply one input pattern for n cycles; report high samples and first index.
  task automatic seg(input bit e, input bit p, input bit r, input int n,
                     output int hits, output int first);
    hits = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      en = e; pend = p; rdy = r;
      @(negedge clk);
      if (timeout_o) begin
        hits++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic idle1();
    int h, f;
    seg(1'b0, 1'b0, 1'b0, 1, h, f);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, f;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    check(timeout_o == 1'b0, "R8", int'(timeout_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(timeout_o == 1'b0, "R8", int'(timeout_o), 0);

    // R2: P=2, L=3 -> expiry after 9 stalled cycles
    cur_req = "R2"; presc = 12'd2; lim = 12'd3;
    seg(1, 1, 0, 12, h, f);
    check(f == 9, "R2", f, 9);
    // R3: single-cycle pulse
    check(h == 1, "R3", h, 1);
    idle1();

    // R7: limit 0 acts as 1
    cur_req = "R7"; presc = 12'd1; lim = 12'd0;
    seg(1, 1, 0, 5, h, f);
    check(f == 2, "R7", f, 2);
    idle1();

    // R4: one-shot, re-arm after a break
    cur_req = "R4"; presc = 12'd0; lim = 12'd2;
    seg(1, 1, 0, 10, h, f);
    check(h == 1 && f == 2, "R4", h, 1);
    idle1();
    seg(1, 1, 0, 4, h, f);
    check(f == 2, "R4", f, 2);
    idle1();

    // R5: accepted beat restarts timing (target 6)
    cur_req = "R5"; presc = 12'd1; lim = 12'd3;
    seg(1, 1, 0, 5, h, f);
    check(h == 0, "R5", h, 0);
    seg(1, 1, 1, 1, h, f);
    check(h == 0, "R5", h, 0);
    seg(1, 1, 0, 8, h, f);
    check(f == 6, "R5", f, 6);
    idle1();

    // R6: enable cleared exactly on the would-be expiry cycle
    cur_req = "R6";
    seg(1, 1, 0, 5, h, f);
    seg(0, 1, 0, 1, h, f);
    check(h == 0, "R6", h, 0);
    seg(1, 1, 0, 5, h, f);
    check(h == 0, "R6", h, 0);
    seg(1, 1, 0, 1, h, f);
    check(h == 1, "R6", h, 1);
    idle1();

    // R9: transfer drained stops the timer
    cur_req = "R9";
    seg(1, 1, 0, 4, h, f);
    seg(1, 0, 0, 1, h, f);
    check(h == 0, "R9", h, 0);
    seg(1, 1, 0, 7, h, f);
    check(f == 6, "R9", f, 6);
    idle1();

    // R1: non-stall patterns never time out
    cur_req = "R1"; presc = 12'd0; lim = 12'd1;
    seg(1, 1, 1, 20, h, f);
    check(h == 0, "R1", h, 0);
    seg(0, 1, 0, 20, h, f);
    check(h == 0, "R1", h, 0);
    seg(1, 0, 0, 20, h, f);
    check(h == 0, "R1", h, 0);

    // Random runs, settings change only during non-stalled cycles (R2)
    cur_req = "R2";
    for (int k = 0; k < 300; k++) begin
      int pat;
      en = 1'b0; pend = 1'b0; rdy = 1'b0;
      pat = int'($urandom_range(0, 2));
      if (pat == 0) en = 1'b0; else if (pat == 1) pend = 1'b0; else begin en = 1; pend = 1; rdy = 1; end
      en = (pat == 2) ? 1'b1 : 1'b0;
      presc = 12'($urandom_range(0, 3));
      lim   = 12'($urandom_range(0, 4));
      @(negedge clk);
      seg(1, 1, 0, int'($urandom_range(1, 30)), h, f);
      if ($urandom_range(0, 3) == 0) seg(1'($urandom), 1'($urandom), 1'($urandom), 2, h, f);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule